// File: doc/BRIEF.md
# LCD Controller Register Block

This block is the software-visible register file of a color LCD controller. A simple single-cycle bus selects one 32-bit word by its word address. Reads are combinational and writes land on the next clock edge. The block stores:

- four panel timing words;
- two frame-buffer base addresses, one for the upper panel half and one for the lower;
- a control word;
- an interrupt mask.

It keeps a small raw interrupt-status vector. Other parts of the controller raise bits in that vector, and software clears them by writing a one-hot-style clear word.

From the stored words the block derives the panel width and height in pixels, the pixel-depth code and a display-on flag, and drives them to the rest of the controller. It also drives a single interrupt line. A range of addresses is passed straight through to an external palette store. A small read-only window returns fixed identification bytes. Accesses that hit no defined location read as zero and raise a one-cycle error flag. A static strap input exchanges the addresses of the mask and control words so that one design serves both board variants.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset every stored word and the raw status are zero, so the outputs are width 16, height 1, depth code 0, display off and interrupt low.
- R2: The word address is `bus_word`. Word offsets 0 to 3 are timing words and 4 and 5 are the upper and lower base addresses, all read/write. With `alt_map` low, offset 6 is the mask (low IRQ_W bits kept) and offset 7 is control. A write takes effect at the next edge, and a read returns the stored value in the same cycle.
- R3: With `alt_map` high, the mask and control words exchange offsets: control is at 6 and the mask at 7.
- R4: `panel_width` equals (timing0[7:2] + 1) * 16, which is the same as ((timing0 & 0xFC) + 4) * 4. `panel_height` equals timing1[9:0] + 1.
- R5: `depth_code` is control[3:1]. `disp_on` is high only when control bit 0 and control bit 11 are both set.
- R6: Offset 8 reads the raw status and offset 9 reads raw AND mask, both zero-extended. `irq` is high when any masked bit is set.
- R7: A write to offset 10 clears every raw bit whose data bit is one. A bit raised on `stat_set` in the same cycle stays set. A raise becomes visible one edge later. Offset 10 reads as zero without an error.
- R8: Offsets 11 and 12 read the upper and lower base addresses. Writes to offsets 8, 9, 11 and 12 change nothing.
- R9: Word addresses 0x3F8 to 0x3FF read the identification bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order, zero-extended. Writes there change nothing.
- R10: Word addresses 0x080 to 0x0FF form the palette window. On an access there, `pal_sel` is high in the same cycle, `pal_wr` follows `bus_wr`, `pal_idx` is the word address bits [6:0], `pal_wdata` equals `bus_wdata`, and a read returns `pal_rdata`.
- R11: Any other word address reads as zero and raises `bus_err` for exactly the cycle after the access. A write there changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alt_map | input | 1 | Strap that exchanges the mask and control offsets |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 10 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| bus_err | output | 1 | Undefined-access flag, one cycle after the access |
| stat_set | input | IRQ_W | Raise raw status bits |
| pal_sel | output | 1 | Palette window access |
| pal_wr | output | 1 | Palette write |
| pal_idx | output | 7 | Palette entry index |
| pal_wdata | output | DATA_W | Palette write data |
| pal_rdata | input | DATA_W | Palette read data |
| panel_width | output | 11 | Derived width in pixels |
| panel_height | output | 11 | Derived height in lines |
| depth_code | output | 3 | Pixel-depth code |
| disp_on | output | 1 | Enable AND power |
| irq | output | 1 | OR of masked status |

## Verification
The bench builds the block with the default DATA_W of 32 and IRQ_W of 4. A four-bit status vector lets random raise and clear words regularly hit all-ones, all-zeros and bit-for-bit collisions between a raise and a clear in the same cycle. It also lets the mask cover the status both fully and not at all. The 32-bit data width keeps control bit 11 and the full timing fields reachable, so the extreme geometry of 1024 by 1024 and the power-gated enable can both be driven.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  typedef enum logic [1:0] {RG_REG, RG_PAL, RG_ID, RG_NONE} region_e;

  localparam logic [3:0] OFS_TIM3    = 4'd3;
  localparam logic [3:0] OFS_UPBASE  = 4'd4;
  localparam logic [3:0] OFS_LOBASE  = 4'd5;
  localparam logic [3:0] OFS_MASK    = 4'd6;
  localparam logic [3:0] OFS_CTRL    = 4'd7;
  localparam logic [3:0] OFS_RAW     = 4'd8;
  localparam logic [3:0] OFS_MSK_ST  = 4'd9;
  localparam logic [3:0] OFS_CLEAR   = 4'd10;
  localparam logic [3:0] OFS_CUR_UP  = 4'd11;
  localparam logic [3:0] OFS_CUR_LO  = 4'd12;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    id_byte = 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
(
  input  logic [9:0] word,
  input  logic       alt_map,
  output region_e    region,
  output logic [3:0] reg_ofs,
  output logic [6:0] pal_idx,
  output logic [2:0] id_idx
);
  always_comb begin
    region  = RG_NONE;
    reg_ofs = word[3:0];
    pal_idx = word[6:0];
    id_idx  = word[2:0];
    if (word[9:3] == 7'h7F) begin
      region = RG_ID;
    end else if (word[9:7] == 3'b001) begin
      region = RG_PAL;
    end else if (word[9:4] == 6'd0 && word[3:0] <= OFS_CUR_LO) begin
      region = RG_REG;
      if (alt_map && word[3:0] == OFS_MASK)      reg_ofs = OFS_CTRL;
      else if (alt_map && word[3:0] == OFS_CTRL) reg_ofs = OFS_MASK;
    end
  end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] stat_set,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_mask,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_q, raw_d;
  logic             raw_en;

  always_comb begin
    raw_en = clr_en || (stat_set != '0);
    raw_d  = raw_q;
    if (clr_en) raw_d = raw_d & ~clr_mask;
    raw_d = raw_d | stat_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  assign raw    = raw_q;
  assign masked = raw_q & mask;
  assign irq    = |masked;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_set != '0) |=> ((raw_q & $past(stat_set)) == $past(stat_set))); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_en && stat_set == '0) |=> ((raw_q & $past(clr_mask)) == '0)); // R7
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
  parameter int GEOM_W = 11
) (
  input  logic [5:0]        hfield,
  input  logic [9:0]        vfield,
  input  logic [2:0]        depth_in,
  input  logic              en_bit,
  input  logic              pwr_bit,
  output logic [GEOM_W-1:0] width,
  output logic [GEOM_W-1:0] height,
  output logic [2:0]        depth,
  output logic              on
);
  always_comb begin
    width  = GEOM_W'({1'b0, hfield} + 7'd1) << 4;
    height = GEOM_W'(vfield) + GEOM_W'(1);
    depth  = depth_in;
    on     = en_bit && pwr_bit;
  end
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
  import lcdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_map,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [9:0]        bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [IRQ_W-1:0]  stat_set,
  output logic              pal_sel,
  output logic              pal_wr,
  output logic [6:0]        pal_idx,
  output logic [DATA_W-1:0] pal_wdata,
  input  logic [DATA_W-1:0] pal_rdata,
  output logic [10:0]       panel_width,
  output logic [10:0]       panel_height,
  output logic [2:0]        depth_code,
  output logic              disp_on,
  output logic              irq
);
  localparam int N_TIM  = 4;
  localparam int GEOM_W = 11;
  localparam int PAD_W  = DATA_W - IRQ_W;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  region_e    region;
  logic [3:0] ofs;
  logic [2:0] id_idx;

  lcdc_decode u_dec (
    .word    (bus_word),
    .alt_map (alt_map),
    .region  (region),
    .reg_ofs (ofs),
    .pal_idx (pal_idx),
    .id_idx  (id_idx)
  );

  logic reg_wr;
  assign reg_wr = bus_sel && bus_wr && (region == RG_REG);

  logic [DATA_W-1:0] tim_q [N_TIM];
  logic [DATA_W-1:0] up_q, lo_q, ctrl_q;
  logic [IRQ_W-1:0]  mask_q;

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    logic tim_we;
    assign tim_we = reg_wr && (ofs == 4'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     tim_q[g] <= '0;
      else if (tim_we) tim_q[g] <= bus_wdata;
    end
  end

  logic up_we, lo_we, ctrl_we, mask_we, clr_en;
  always_comb begin
    up_we   = reg_wr && (ofs == OFS_UPBASE);
    lo_we   = reg_wr && (ofs == OFS_LOBASE);
    ctrl_we = reg_wr && (ofs == OFS_CTRL);
    mask_we = reg_wr && (ofs == OFS_MASK);
    clr_en  = reg_wr && (ofs == OFS_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= '0;
      lo_q   <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (up_we)   up_q   <= bus_wdata;
      if (lo_we)   lo_q   <= bus_wdata;
      if (ctrl_we) ctrl_q <= bus_wdata;
      if (mask_we) mask_q <= bus_wdata[IRQ_W-1:0];
    end
  end

  logic [IRQ_W-1:0] raw_st, msk_st;

  lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .stat_set (stat_set),
    .clr_en   (clr_en),
    .clr_mask (bus_wdata[IRQ_W-1:0]),
    .mask     (mask_q),
    .raw      (raw_st),
    .masked   (msk_st),
    .irq      (irq)
  );

  lcdc_geom #(.GEOM_W(GEOM_W)) u_geom (
    .hfield   (tim_q[0][7:2]),
    .vfield   (tim_q[1][9:0]),
    .depth_in (ctrl_q[3:1]),
    .en_bit   (ctrl_q[0]),
    .pwr_bit  (ctrl_q[11]),
    .width    (panel_width),
    .height   (panel_height),
    .depth    (depth_code),
    .on       (disp_on)
  );

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_PAL: bus_rdata = pal_rdata;
      RG_ID:  bus_rdata = DATA_W'(id_byte(id_idx));
      RG_REG: begin
        if (ofs <= OFS_TIM3) bus_rdata = tim_q[ofs[1:0]];
        else begin
          case (ofs)
            OFS_UPBASE, OFS_CUR_UP: bus_rdata = up_q;
            OFS_LOBASE, OFS_CUR_LO: bus_rdata = lo_q;
            OFS_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_RAW:    bus_rdata = {{PAD_W{1'b0}}, raw_st};
            OFS_MSK_ST: bus_rdata = {{PAD_W{1'b0}}, msk_st};
            default:    bus_rdata = '0;
          endcase
        end
      end
      default: bus_rdata = '0;
    endcase
  end

  assign pal_sel   = bus_sel && (region == RG_PAL);
  assign pal_wr    = pal_sel && bus_wr;
  assign pal_wdata = bus_wdata;

  logic err_q, err_d;
  assign err_d = bus_sel && (region == RG_NONE);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end
  assign bus_err = err_q;

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_err |-> $past(bus_sel)); // R11
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_sel && bus_wr) |=> $stable(up_q)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_sel && bus_wr) |=> $stable(ctrl_q)); // R2
endmodule

// File: tb/lcdc_regfile_tb.sv
module lcdc_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int IRQ_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alt_map;
  logic              bus_sel, bus_wr;
  logic [9:0]        bus_word;
  logic [DATA_W-1:0] bus_wdata, bus_rdata, pal_wdata, pal_rdata;
  logic              bus_err, pal_sel, pal_wr, disp_on, irq;
  logic [IRQ_W-1:0]  stat_set;
  logic [6:0]        pal_idx;
  logic [10:0]       panel_width, panel_height;
  logic [2:0]        depth_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pal_rdata = 32'h5A00_0000 | {25'd0, pal_idx};

  lcdc_regfile #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .alt_map(alt_map),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .stat_set(stat_set), .pal_sel(pal_sel), .pal_wr(pal_wr),
    .pal_idx(pal_idx), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
    .panel_width(panel_width), .panel_height(panel_height),
    .depth_code(depth_code), .disp_on(disp_on), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0]      m_tim [4];
  logic [31:0]      m_up, m_lo, m_ctrl;
  logic [IRQ_W-1:0] m_mask, m_raw;
  logic             m_err;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_ref(input int i);
    logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  // kind: 0 reg, 1 palette, 2 id, 3 undefined
  function automatic int kind_of(input logic [9:0] w);
    if (w >= 10'h3F8) return 2;
    if (w >= 10'h080 && w <= 10'h0FF) return 1;
    if (w <= 10'd12) return 0;
    return 3;
  endfunction

  function automatic int eff_ofs(input logic [9:0] w);
    if (alt_map && w == 10'd6) return 7;
    if (alt_map && w == 10'd7) return 6;
    return int'(w);
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] w);
    int k = kind_of(w);
    if (k == 1) return 32'h5A00_0000 | {25'd0, w[6:0]};
    if (k == 2) return {24'd0, id_ref(int'(w[2:0]))};
    if (k == 3) return '0;
    case (eff_ofs(w))
      0, 1, 2, 3: return m_tim[w[1:0]];
      4, 11:      return m_up;
      5, 12:      return m_lo;
      6:          return {28'd0, m_mask};
      7:          return m_ctrl;
      8:          return {28'd0, m_raw};
      9:          return {28'd0, m_raw & m_mask};
      default:    return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [9:0] w);
    int k = kind_of(w);
    if (k == 1) return "R10";
    if (k == 2) return "R9";
    if (k == 3) return "R11";
    if (w == 10'd6 || w == 10'd7) return alt_map ? "R3" : "R2";
    if (w == 10'd8 || w == 10'd9) return "R6";
    if (w == 10'd10) return "R7";
    if (w >= 10'd11) return "R8";
    return "R2";
  endfunction

  task automatic step(input logic s, input logic w, input logic [9:0] a,
                      input logic [31:0] d, input logic [IRQ_W-1:0] st);
    int k;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_word = a; bus_wdata = d; stat_set = st;
    #1;
    k = kind_of(a);
    check("R11 err flag", {31'd0, bus_err}, {31'd0, m_err});
    check("R6 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    check("R4 width", {21'd0, panel_width}, 32'((int'(m_tim[0][7:2]) + 1) * 16));
    check("R4 height", {21'd0, panel_height}, 32'(int'(m_tim[1][9:0]) + 1));
    check("R5 depth", {29'd0, depth_code}, {29'd0, m_ctrl[3:1]});
    check("R5 disp_on", {31'd0, disp_on}, {31'd0, m_ctrl[0] & m_ctrl[11]});
    if (s && !w) check(req_of(a), bus_rdata, exp_read(a));
    check("R10 pal_sel", {31'd0, pal_sel}, {31'd0, s && k == 1});
    if (s && k == 1) begin
      check("R10 pal_idx", {25'd0, pal_idx}, {25'd0, a[6:0]});
      check("R10 pal_wr", {31'd0, pal_wr}, {31'd0, w});
      if (w) check("R10 pal_wdata", pal_wdata, d);
    end
    // model the state after the coming edge
    if (s && w && k == 0) begin
      case (eff_ofs(a))
        0, 1, 2, 3: m_tim[a[1:0]] = d;
        4: m_up = d;
        5: m_lo = d;
        6: m_mask = d[IRQ_W-1:0];
        7: m_ctrl = d;
        10: m_raw = m_raw & ~d[IRQ_W-1:0];
        default: ;
      endcase
    end
    m_raw = m_raw | st;
    m_err = s && k == 3;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 10'd0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_tim[i] = '0;
    m_up = '0; m_lo = '0; m_ctrl = '0; m_mask = '0; m_raw = '0; m_err = 1'b0;
    rst_n = 1'b0; alt_map = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_word = '0; bus_wdata = '0; stat_set = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values
    @(negedge clk); #1;
    check("R1 width", {21'd0, panel_width}, 32'd16);
    check("R1 height", {21'd0, panel_height}, 32'd1);
    check("R1 depth", {29'd0, depth_code}, 32'd0);
    check("R1 disp_on", {31'd0, disp_on}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int w = 0; w <= 12; w++) step(1'b1, 1'b0, 10'(w), '0, '0);

    // R4 extreme geometry
    step(1'b1, 1'b1, 10'd0, 32'hFFFF_FFFF, '0);
    step(1'b1, 1'b1, 10'd1, 32'h0000_03FF, '0);
    idle();
    step(1'b1, 1'b1, 10'd0, 32'h0000_0003, '0);
    idle();
    // R5 enable needs power
    step(1'b1, 1'b1, 10'd7, 32'h0000_0001, '0);
    idle();
    step(1'b1, 1'b1, 10'd7, 32'h0000_080B, '0);
    idle();
    // R6 / R7 set, mask, clear, set-wins collision
    step(1'b1, 1'b1, 10'd6, 32'h0000_0005, 4'b0110);
    step(1'b1, 1'b0, 10'd8, '0, '0);
    step(1'b1, 1'b0, 10'd9, '0, '0);
    step(1'b1, 1'b1, 10'd10, 32'h0000_000F, 4'b0100);
    step(1'b1, 1'b0, 10'd8, '0, '0);
    step(1'b1, 1'b0, 10'd10, '0, '0);
    // R8 read-only writes ignored
    step(1'b1, 1'b1, 10'd4, 32'hCAFE_0000, '0);
    step(1'b1, 1'b1, 10'd11, 32'h1234_5678, '0);
    step(1'b1, 1'b1, 10'd12, 32'h1234_5678, '0);
    step(1'b1, 1'b1, 10'd8, 32'hFFFF_FFFF, '0);
    step(1'b1, 1'b1, 10'd9, 32'hFFFF_FFFF, '0);
    step(1'b1, 1'b0, 10'd11, '0, '0);
    step(1'b1, 1'b0, 10'd8, '0, '0);
    // R9 id window, writes ignored
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 10'(10'h3F8 + i), '0, '0);
    step(1'b1, 1'b1, 10'h3F9, 32'hFFFF_FFFF, '0);
    step(1'b1, 1'b0, 10'h3F9, '0, '0);
    // R10 palette edges
    step(1'b1, 1'b1, 10'h080, 32'hDEAD_BEEF, '0);
    step(1'b1, 1'b0, 10'h0FF, '0, '0);
    // R11 undefined: read, write with no effect, back-to-back
    step(1'b1, 1'b0, 10'd13, '0, '0);
    step(1'b1, 1'b1, 10'h07F, 32'hFFFF_FFFF, '0);
    step(1'b1, 1'b0, 10'h3F7, '0, '0);
    idle();
    for (int w = 0; w <= 12; w++) step(1'b1, 1'b0, 10'(w), '0, '0);

    // R3 strap phase
    for (int ph = 0; ph < 2; ph++) begin
      @(negedge clk);
      alt_map = ph[0] ? 1'b0 : 1'b1;
      step(1'b1, 1'b1, 10'd6, 32'h0000_0803, '0);
      step(1'b1, 1'b0, 10'd6, '0, '0);
      step(1'b1, 1'b1, 10'd7, 32'h0000_0009, '0);
      step(1'b1, 1'b0, 10'd7, '0, '0);
      for (int n = 0; n < 1500; n++) begin
        int sel = int'($urandom % 8);
        logic [9:0] a;
        logic [31:0] d = $urandom;
        logic [IRQ_W-1:0] st = ($urandom % 4 == 0) ? IRQ_W'($urandom) : '0;
        case (sel)
          0: a = 10'($urandom % 16);
          1: a = 10'(10'h080 + $urandom % 128);
          2: a = 10'(10'h3F8 + $urandom % 8);
          3: a = ($urandom % 2 == 0) ? 10'(13 + $urandom % 115) : 10'(10'h100 + $urandom % 760);
          4: a = ($urandom % 2 == 0) ? 10'd10 : 10'd6 + 10'($urandom % 2);
          default: a = 10'($urandom % 13);
        endcase
        step($urandom % 6 != 0, $urandom % 2 == 0, a, d, st);
      end
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule